// File: doc/BRIEF.md
# Serial Transceiver Status Flag Controller

This block owns the eight-bit status byte of an asynchronous serial transceiver. The transmit and receive datapaths report events as single-cycle strobes: a word moved into the transmit shifter, a frame finished, a word received with its noise, framing and parity qualifiers, or an idle line. The block turns each strobe into a sticky flag. It decides whether a received word may be loaded into the receive holding register. It combines the flags with per-source enable bits into one interrupt request.

Software clears flags with a two-step bus sequence. A read of the status address arms a clear. The next access to the data address consumes that arming. A data write then clears the transmit flags, and a data read clears the receive and error flags. The parity flag clears on either kind of data access. Writes to the status address have no effect. A new event that arrives in the same cycle as a clear keeps its flag set.

Top module: `sio_status_ctl`

## Requirements
- R1: After reset the status byte is 0xC0. The bit layout is [7] transmit empty, [6] transmit complete, [5] receive ready, [4] idle, [3] overrun, [2] noise, [1] framing, [0] parity.
- R2: `ev_tx_load` sets bit 7. `ev_tx_done` with `tx_kind` = 0 (data) sets bit 6.
- R3: A data write (`bus_wr`=1, `bus_is_data`=1) that follows an earlier status read clears bits 7 and 6. A data write with no status read before it leaves them unchanged.
- R4: A data read that follows an earlier status read clears bits 5, 4, 3, 2 and 1.
- R5: `ev_tx_done` with `tx_kind` = 1 (preamble) or 2 (break) does not set bit 6.
- R6: Once the idle flag has been set, `ev_idle` cannot set it again until a received word has been loaded.
- R7: A word that completes while bit 5 is set sets bit 3. `rx_load` stays low, and the word's noise, framing and parity qualifiers set no flag.
- R8: A word with both a framing error and an overrun sets bit 3 only. Bit 1 stays clear.
- R9: `irq` = (b7 & `ie_txe`) | (b6 & `ie_tc`) | ((b5|b3) & `ie_rx`) | (b4 & `ie_idle`) | (b0 & `ie_par`). Bits 2 and 1 never raise it.
- R10: Bit 0 can set only while `parity_en`=1. A data read or a data write that follows a status read clears it.
- R11: A write to the status address changes no flag and does not arm a clear. A single status read arms exactly one clear, which the first data access after it consumes.
- R12: When a set event and a clear for the same flag fall in one cycle, the flag ends up set.
- R13: When a word completes while bit 5 is clear, `rx_load` is high in that same cycle. The next cycle shows bit 5 set, together with the word's noise and framing flags, and its parity flag when parity checking is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_tx_load | input | 1 | Transmit word moved into the shifter |
| ev_tx_done | input | 1 | Transmit frame finished |
| tx_kind | input | 2 | Kind of finished frame: 0 data, 1 preamble, 2 break |
| ev_rx_word | input | 1 | Received word complete in the shifter |
| rx_noise | input | 1 | Noise seen on the completing word |
| rx_frame_err | input | 1 | Framing error on the completing word |
| rx_parity_bad | input | 1 | Parity mismatch on the completing word |
| ev_idle | input | 1 | Idle line detected |
| parity_en | input | 1 | Parity checking enabled |
| ie_txe | input | 1 | Interrupt enable, transmit empty |
| ie_tc | input | 1 | Interrupt enable, transmit complete |
| ie_rx | input | 1 | Interrupt enable, receive ready or overrun |
| ie_idle | input | 1 | Interrupt enable, idle |
| ie_par | input | 1 | Interrupt enable, parity error |
| bus_rd | input | 1 | Bus read strobe |
| bus_wr | input | 1 | Bus write strobe |
| bus_is_data | input | 1 | 1 selects the data address, 0 the status address |
| status | output | 8 | Status byte |
| irq | output | 1 | Combined interrupt request |
| rx_load | output | 1 | Move the received word into the holding register |

## Verification
The clear sequence is tried in three forms: a status read followed by a data write, a status read followed by a data read, and a bare data access with no arming. These show that each access type clears only its own group of flags, and only when armed. Received words arrive with the ready flag both clear and set, and with several combinations of noise, framing and parity qualifiers. These separate a normal load from an overrun, and show whether the framing flag is suppressed when both errors occur. Idle strobes are given before and after a fresh word to expose the re-arming rule. The interrupt enables are stepped one at a time over known flag patterns, which shows that noise and framing stay silent.

// File: rtl/sio_status_pkg.sv
package sio_status_pkg;

  localparam int STAT_W = 8;

  // bit positions of the status byte (software decodes them)
  localparam int B_TXE   = 7;
  localparam int B_TC    = 6;
  localparam int B_RXR   = 5;
  localparam int B_IDLE  = 4;
  localparam int B_OVR   = 3;
  localparam int B_NOISE = 2;
  localparam int B_FRAME = 1;
  localparam int B_PAR   = 0;

  localparam logic [STAT_W-1:0] STAT_RST = 8'hC0;

  // groups cleared by each second step of the sequence
  localparam logic [STAT_W-1:0] CLR_ON_WR_MASK =
    (8'b1 << B_TXE) | (8'b1 << B_TC) | (8'b1 << B_PAR);
  localparam logic [STAT_W-1:0] CLR_ON_RD_MASK =
    (8'b1 << B_RXR) | (8'b1 << B_IDLE) | (8'b1 << B_OVR) |
    (8'b1 << B_NOISE) | (8'b1 << B_FRAME) | (8'b1 << B_PAR);

  localparam int KIND_W = 2;
  typedef enum logic [KIND_W-1:0] {
    TXK_DATA     = 2'd0,
    TXK_PREAMBLE = 2'd1,
    TXK_BREAK    = 2'd2
  } tx_kind_e;

  typedef struct packed {
    logic txe;
    logic tc;
    logic rx;
    logic idle;
    logic par;
  } irq_en_t;

  function automatic logic irq_from(input logic [STAT_W-1:0] s, input irq_en_t en);
    logic r;
    r = (s[B_TXE] & en.txe) |
        (s[B_TC] & en.tc) |
        ((s[B_RXR] | s[B_OVR]) & en.rx) |
        (s[B_IDLE] & en.idle) |
        (s[B_PAR] & en.par);
    return r;
  endfunction

  function automatic logic [STAT_W-1:0] clear_vec(input logic on_wr, input logic on_rd);
    logic [STAT_W-1:0] v;
    v = ({STAT_W{on_wr}} & CLR_ON_WR_MASK) | ({STAT_W{on_rd}} & CLR_ON_RD_MASK);
    return v;
  endfunction

endpackage

// File: rtl/sio_clear_seq.sv
module sio_clear_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_rd,
  input  logic bus_wr,
  input  logic bus_is_data,
  output logic armed,
  output logic clr_on_wr,
  output logic clr_on_rd
);

  logic stat_rd;
  logic data_acc;
  logic armed_q;

  assign stat_rd  = bus_rd & ~bus_is_data;
  assign data_acc = (bus_rd | bus_wr) & bus_is_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (stat_rd) begin
      armed_q <= 1'b1;
    end else if (data_acc) begin
      armed_q <= 1'b0;
    end
  end

  assign armed     = armed_q;
  assign clr_on_wr = armed_q & bus_is_data & bus_wr;
  assign clr_on_rd = armed_q & bus_is_data & bus_rd;

  // R11: one arming serves exactly one data access
  p_arm_consumed_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc) |=> !armed);

  // R11: a status write never arms
  p_status_wr_no_arm_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && bus_wr && !bus_is_data && !bus_rd) |=> !armed);

endmodule

// File: rtl/sio_rx_qualify.sv
module sio_rx_qualify (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_rx_word,
  input  logic rx_noise,
  input  logic rx_frame_err,
  input  logic rx_parity_bad,
  input  logic parity_en,
  input  logic ev_idle,
  input  logic rxr_now,
  output logic rx_load,
  output logic set_rxr,
  output logic set_ovr,
  output logic set_noise,
  output logic set_frame,
  output logic set_par,
  output logic set_idle,
  output logic idle_allow
);

  logic allow_q;
  logic overrun_hit;

  assign overrun_hit = ev_rx_word & rxr_now;
  assign rx_load     = ev_rx_word & ~rxr_now;

  // qualifiers ride only on an accepted word; a dropped word reports overrun alone
  assign set_rxr   = rx_load;
  assign set_ovr   = overrun_hit;
  assign set_noise = rx_load & rx_noise;
  assign set_frame = rx_load & rx_frame_err;
  assign set_par   = rx_load & rx_parity_bad & parity_en;
  assign set_idle  = ev_idle & allow_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      allow_q <= 1'b1;
    end else if (rx_load) begin
      allow_q <= 1'b1;
    end else if (set_idle) begin
      allow_q <= 1'b0;
    end
  end

  assign idle_allow = allow_q;

  // R6: after an idle report, no further report without a fresh word
  p_idle_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_idle && !rx_load) |=> !idle_allow);

  // R7: overrun never loads the holding register
  p_overrun_no_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_word && rxr_now) |-> !rx_load);

endmodule

// File: rtl/sio_flag_bank.sv
module sio_flag_bank
  import sio_status_pkg::*;
#(
  parameter int                 W       = STAT_W,
  parameter logic [W-1:0]       RST_VAL = STAT_RST
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] flags
);

  for (genvar i = 0; i < W; i++) begin : g_cell
    logic q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= RST_VAL[i];
      end else if (set_vec[i]) begin
        q <= 1'b1;
      end else if (clr_vec[i]) begin
        q <= 1'b0;
      end
    end
    assign flags[i] = q;

    // R12: a set in the same cycle as a clear leaves the flag set
    p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> flags[i]);
  end

endmodule

// File: rtl/sio_irq_merge.sv
module sio_irq_merge
  import sio_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] stat,
  input  irq_en_t           en,
  output logic              irq
);

  assign irq = irq_from(stat, en);

  // R9: noise and framing alone never request service
  p_irq_silent_errs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat & ~((8'b1 << B_NOISE) | (8'b1 << B_FRAME))) == '0) |-> !irq);

  // R9: with all enables off the line is low
  p_irq_all_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq);

endmodule

// File: rtl/sio_status_ctl.sv
module sio_status_ctl
  import sio_status_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_tx_load,
  input  logic       ev_tx_done,
  input  logic [1:0] tx_kind,
  input  logic       ev_rx_word,
  input  logic       rx_noise,
  input  logic       rx_frame_err,
  input  logic       rx_parity_bad,
  input  logic       ev_idle,
  input  logic       parity_en,
  input  logic       ie_txe,
  input  logic       ie_tc,
  input  logic       ie_rx,
  input  logic       ie_idle,
  input  logic       ie_par,
  input  logic       bus_rd,
  input  logic       bus_wr,
  input  logic       bus_is_data,
  output logic [7:0] status,
  output logic       irq,
  output logic       rx_load
);

  logic              armed;
  logic              clr_on_wr;
  logic              clr_on_rd;
  logic              set_rxr, set_ovr, set_noise, set_frame, set_par, set_idle;
  logic              idle_allow;
  logic              tc_event;
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] clr_vec;
  logic [STAT_W-1:0] flags;
  irq_en_t           en;

  sio_clear_seq u_clr (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_is_data (bus_is_data),
    .armed       (armed),
    .clr_on_wr   (clr_on_wr),
    .clr_on_rd   (clr_on_rd)
  );

  sio_rx_qualify u_rxq (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_rx_word    (ev_rx_word),
    .rx_noise      (rx_noise),
    .rx_frame_err  (rx_frame_err),
    .rx_parity_bad (rx_parity_bad),
    .parity_en     (parity_en),
    .ev_idle       (ev_idle),
    .rxr_now       (flags[B_RXR]),
    .rx_load       (rx_load),
    .set_rxr       (set_rxr),
    .set_ovr       (set_ovr),
    .set_noise     (set_noise),
    .set_frame     (set_frame),
    .set_par       (set_par),
    .set_idle      (set_idle),
    .idle_allow    (idle_allow)
  );

  // only a data character completes a transmission
  assign tc_event = ev_tx_done & (tx_kind_e'(tx_kind) == TXK_DATA);

  always_comb begin
    set_vec          = '0;
    set_vec[B_TXE]   = ev_tx_load;
    set_vec[B_TC]    = tc_event;
    set_vec[B_RXR]   = set_rxr;
    set_vec[B_IDLE]  = set_idle;
    set_vec[B_OVR]   = set_ovr;
    set_vec[B_NOISE] = set_noise;
    set_vec[B_FRAME] = set_frame;
    set_vec[B_PAR]   = set_par;
  end

  assign clr_vec = clear_vec(clr_on_wr, clr_on_rd);

  sio_flag_bank #(
    .W       (STAT_W),
    .RST_VAL (STAT_RST)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .flags   (flags)
  );

  assign en.txe  = ie_txe;
  assign en.tc   = ie_tc;
  assign en.rx   = ie_rx;
  assign en.idle = ie_idle;
  assign en.par  = ie_par;

  sio_irq_merge u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .stat  (flags),
    .en    (en),
    .irq   (irq)
  );

  assign status = flags;

  // R5: non-data frames leave transmit-complete alone
  p_tc_only_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tx_done && tx_kind != 2'd0 && !status[B_TC]) |=> !status[B_TC]);

  // R8: an overrun word never raises the framing flag
  p_frame_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_word && status[B_RXR] && !status[B_FRAME]) |=> !status[B_FRAME]);

  // R10: parity flag cannot rise while checking is off
  p_par_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!parity_en && !status[B_PAR]) |=> !status[B_PAR]);

  // R4: receive-ready falls only after an armed data read
  p_rxr_clear_path_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (status[B_RXR] && !(armed && bus_rd && bus_is_data)) |=> status[B_RXR]);

  // R3: transmit-empty falls only after an armed data write
  p_txe_clear_path_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (status[B_TXE] && !(armed && bus_wr && bus_is_data)) |=> status[B_TXE]);

  // R13: an accepted word shows up as receive-ready next cycle
  p_load_sets_rxr_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load |=> status[B_RXR]);

endmodule

// File: tb/sim_sio_status_ctl.sv
`timescale 1ns/1ps
module sim_sio_status_ctl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_tx_load = 0, ev_tx_done = 0, ev_rx_word = 0;
  logic [1:0] tx_kind = 0;
  logic       rx_noise = 0, rx_frame_err = 0, rx_parity_bad = 0, ev_idle = 0;
  logic       parity_en = 0;
  logic       ie_txe = 0, ie_tc = 0, ie_rx = 0, ie_idle = 0, ie_par = 0;
  logic       bus_rd = 0, bus_wr = 0, bus_is_data = 0;
  logic [7:0] status;
  logic       irq, rx_load;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sio_status_ctl u0 (
    .clk(clk), .rst_n(rst_n),
    .ev_tx_load(ev_tx_load), .ev_tx_done(ev_tx_done), .tx_kind(tx_kind),
    .ev_rx_word(ev_rx_word), .rx_noise(rx_noise), .rx_frame_err(rx_frame_err),
    .rx_parity_bad(rx_parity_bad), .ev_idle(ev_idle), .parity_en(parity_en),
    .ie_txe(ie_txe), .ie_tc(ie_tc), .ie_rx(ie_rx), .ie_idle(ie_idle), .ie_par(ie_par),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_is_data(bus_is_data),
    .status(status), .irq(irq), .rx_load(rx_load)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic cyc;
    @(posedge clk);
    #1;
  endtask

  task automatic stat_read;
    bus_rd = 1; bus_is_data = 0; cyc; bus_rd = 0;
  endtask

  task automatic data_read;
    bus_rd = 1; bus_is_data = 1; cyc; bus_rd = 0; bus_is_data = 0;
  endtask

  task automatic data_write;
    bus_wr = 1; bus_is_data = 1; cyc; bus_wr = 0; bus_is_data = 0;
  endtask

  task automatic rx_word(input logic n, input logic f, input logic p, input logic exp_load, input string req);
    ev_rx_word = 1; rx_noise = n; rx_frame_err = f; rx_parity_bad = p;
    #0.5;
    chk(req, {7'd0, rx_load}, {7'd0, exp_load});
    cyc;
    ev_rx_word = 0; rx_noise = 0; rx_frame_err = 0; rx_parity_bad = 0;
  endtask

  task automatic tx_done(input logic [1:0] k);
    ev_tx_done = 1; tx_kind = k; cyc; ev_tx_done = 0; tx_kind = 0;
  endtask

  task automatic t_reset;
    chk("R1 reset value", status, 8'hC0);
    chk("R1 irq at reset", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_tx;
    data_write;
    chk("R3 unarmed data write", status, 8'hC0);
    bus_wr = 1; bus_is_data = 0; cyc; bus_wr = 0;
    chk("R11 status write ignored", status, 8'hC0);
    data_write;
    chk("R11 status write does not arm", status, 8'hC0);
    stat_read; data_write;
    chk("R3 armed write clears tx flags", status, 8'h00);
    data_write;
    chk("R11 arm consumed", status, 8'h00);
    ev_tx_load = 1; cyc; ev_tx_load = 0;
    chk("R2 tx load sets empty", status, 8'h80);
    tx_done(2'd2);
    chk("R5 break no complete", status, 8'h80);
    tx_done(2'd1);
    chk("R5 preamble no complete", status, 8'h80);
    tx_done(2'd0);
    chk("R2 data frame complete", status, 8'hC0);
    stat_read;
    ev_tx_load = 1; bus_wr = 1; bus_is_data = 1; cyc;
    ev_tx_load = 0; bus_wr = 0; bus_is_data = 0;
    chk("R12 set wins over clear", status, 8'h80);
    tx_done(2'd0);
    chk("R2 complete again", status, 8'hC0);
  endtask

  task automatic t_rx;
    parity_en = 0;
    rx_word(1, 1, 1, 1'b1, "R13 load strobe");
    chk("R13 flags with word, R10 parity off", status, 8'hE6);
    stat_read; data_read;
    chk("R4 armed read clears rx flags", status, 8'hC0);
    parity_en = 1;
    rx_word(0, 0, 0, 1'b1, "R13 load strobe clean");
    chk("R13 clean word", status, 8'hE0);
    rx_word(1, 1, 1, 1'b0, "R7 no load on overrun");
    chk("R8 overrun only", status, 8'hE8);
    stat_read; data_read;
    chk("R4 clear after overrun", status, 8'hC0);
    rx_word(0, 0, 1, 1'b1, "R13 load parity word");
    chk("R10 parity set when enabled", status, 8'hE1);
    stat_read; data_write;
    chk("R10 parity cleared by data write", status, 8'h20);
    stat_read; data_read;
    chk("R4 rx cleared", status, 8'h00);
    ev_tx_load = 1; cyc; ev_tx_load = 0;
    tx_done(2'd0);
    chk("R2 restore tx flags", status, 8'hC0);
  endtask

  task automatic t_idle;
    ev_idle = 1; cyc; ev_idle = 0;
    chk("R6 first idle", status, 8'hD0);
    stat_read; data_read;
    chk("R4 idle cleared", status, 8'hC0);
    ev_idle = 1; cyc; ev_idle = 0;
    chk("R6 idle suppressed", status, 8'hC0);
    rx_word(0, 0, 0, 1'b1, "R13 load rearm");
    stat_read; data_read;
    ev_idle = 1; cyc; ev_idle = 0;
    chk("R6 idle after new word", status, 8'hD0);
    stat_read; data_read;
    chk("R4 idle cleared again", status, 8'hC0);
  endtask

  task automatic t_irq;
    ie_txe = 1; #0.5;
    chk("R9 txe irq", {7'd0, irq}, 8'h01);
    ie_txe = 0; ie_tc = 1; #0.5;
    chk("R9 tc irq", {7'd0, irq}, 8'h01);
    ie_tc = 0; #0.5;
    chk("R9 irq off", {7'd0, irq}, 8'h00);
    stat_read; data_write;
    parity_en = 0;
    rx_word(1, 1, 0, 1'b1, "R13 load noisy");
    chk("R9 pattern", status, 8'h26);
    ie_txe = 1; ie_tc = 1; ie_idle = 1; ie_par = 1; #0.5;
    chk("R9 noise framing silent", {7'd0, irq}, 8'h00);
    ie_rx = 1; #0.5;
    chk("R9 rx ready irq", {7'd0, irq}, 8'h01);
    ie_txe = 0; ie_tc = 0; ie_idle = 0; ie_par = 0; ie_rx = 0;
    stat_read; data_read;
    chk("R4 final clear", status, 8'h00);
  endtask

  initial begin
    repeat (3) cyc;
    rst_n = 1;
    cyc;
    t_reset;
    t_tx;
    t_rx;
    t_idle;
    t_irq;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule